// File: doc/BRIEF.md
# Octal Double-Buffered DAC Register Front End

This block is the digital side of an eight-channel digital-to-analog converter. A host shares one parallel data bus and a channel address across all channels. Each channel holds its code in two stages. The first is a holding stage that a write strobe fills. The second is a converter stage whose contents reach the analog output. A single load strobe moves every holding stage into its converter stage in the same cycle, so that all channels update together.

All strobes are sampled on the rising edge of the clock. While an enable is low, the stage it controls takes a new value on every edge, which is how this block models a transparent latch. When the enable goes high, the stage keeps the value it took at the last edge. A clock edge that sees write and load active together passes bus data through both stages in one edge. The clear input is an override on the outputs only. While clear is low every output shows code zero, and both stages keep their contents.

The bus width and the channel count are parameters. The defaults are 12 bits and eight channels. Synchronous active-high reset sets every stage to zero.

Top module: `dacif_octal`

## Requirements
- R1: While `rst` is high at a rising edge, every holding stage and every converter stage becomes zero. Once clear is released, all eight output codes then read zero.
- R2: A write reaches only the channel whose number equals `addr`. Every other channel's holding stage keeps its value.
- R3: At an edge where `cs_n` or `wr_n` is high, no holding stage changes, whatever the bus and address carry.
- R4: At each edge where `cs_n` and `wr_n` are both low, the addressed holding stage takes the bus value. After either strobe goes high, that stage keeps the last value it took.
- R5: At an edge where `ld_n` is high, no converter stage changes.
- R6: At each edge where `ld_n` is low, all converter stages take their holding stage contents together.
- R7: At an edge where `cs_n`, `wr_n` and `ld_n` are all low, the addressed channel's converter stage takes the bus value directly. Its output shows that value after that single edge.
- R8: While `clr_n` is low, every output code is zero (all bits 0). This takes effect in the same cycle, with no clock edge needed.
- R9: Clear does not alter either stage. Writes and loads made during clear still take effect. When `clr_n` returns high, each output shows its converter stage contents in the same cycle.
- R10: Channel k's code lies in `dac_code[k]`, which is bits k*W to k*W+W-1 of the packed output. Address value k selects channel k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data | input | W (12) | Shared code bus |
| addr | input | 3 | Channel number for writes |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| ld_n | input | 1 | Active-low global load strobe |
| clr_n | input | 1 | Active-low output clear |
| dac_code | output | 8 x W | Per-channel converter codes, packed |

## Verification
The bench writes a distinct code into every channel while load is held high, then pulses load. This separates the holding stage from the converter stage, and it exposes any address decode or slice-order error. It drives a changing bus with only one of the two write strobes active, which shows whether any write leaks past the gate. A write held across several edges with a changing bus shows which value is kept when the strobe is released. A fully transparent sequence then exercises the single-edge path through both stages. Clear is asserted across a write and a load, which shows whether clear forces the outputs at once and whether it leaves the stored contents intact.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    localparam int unsigned DEF_W   = 12;
    localparam int unsigned DEF_NCH = 8;

    // decoded, active-high view of the control strobes
    typedef struct packed {
        logic wr_act;   // write gate open (select and write both low)
        logic ld_act;   // converter stages follow holding stages
        logic clr_act;  // outputs forced to zero scale
    } strobe_t;

    function automatic strobe_t decode_strobes(
        input logic cs_n,
        input logic wr_n,
        input logic ld_n,
        input logic clr_n
    );
        strobe_t s;
        s.wr_act  = ~cs_n & ~wr_n;
        s.ld_act  = ~ld_n;
        s.clr_act = ~clr_n;
        return s;
    endfunction

endpackage

// File: rtl/dacif_decode.sv
module dacif_decode #(
    parameter int unsigned NCH = 8,
    localparam int unsigned AW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [AW-1:0]  addr,
    input  logic           wr_act,
    output logic [NCH-1:0] sel
);

    for (genvar g = 0; g < NCH; g++) begin : g_sel
        assign sel[g] = wr_act && (addr == AW'(g));
    end

endmodule

// File: rtl/dacif_chan.sv
module dacif_chan #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  logic         ld_act,
    input  logic [W-1:0] data,
    output logic [W-1:0] hold_q,
    output logic [W-1:0] conv_q
);

    logic [W-1:0] hold_nxt;
    logic [W-1:0] conv_nxt;

    // holding stage: open only while this channel is addressed
    always_comb begin
        hold_nxt = sel ? data : hold_q;
    end

    // converter stage takes the holding stage's incoming value, so a fully
    // open path passes bus data through both stages in one edge
    always_comb begin
        conv_nxt = ld_act ? hold_nxt : conv_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            conv_q <= '0;
        end else begin
            hold_q <= hold_nxt;
            conv_q <= conv_nxt;
        end
    end

endmodule

// File: rtl/dacif_clr.sv
module dacif_clr #(
    parameter int unsigned NCH = 8,
    parameter int unsigned W   = 12
) (
    input  logic [NCH-1:0][W-1:0] conv_q,
    input  logic                  clr_act,
    output logic [NCH-1:0][W-1:0] code
);

    for (genvar g = 0; g < NCH; g++) begin : g_mux
        assign code[g] = clr_act ? '0 : conv_q[g];
    end

endmodule

// File: rtl/dacif_octal.sv
module dacif_octal
    import dacif_pkg::*;
#(
    parameter int unsigned W   = DEF_W,
    parameter int unsigned NCH = DEF_NCH,
    localparam int unsigned AW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [W-1:0]          data,
    input  logic [AW-1:0]         addr,
    input  logic                  cs_n,
    input  logic                  wr_n,
    input  logic                  ld_n,
    input  logic                  clr_n,
    output logic [NCH-1:0][W-1:0] dac_code
);

    strobe_t               stb;
    logic [NCH-1:0]        sel;
    logic [NCH-1:0][W-1:0] hold_stage;
    logic [NCH-1:0][W-1:0] conv_stage;

    assign stb = decode_strobes(cs_n, wr_n, ld_n, clr_n);

    dacif_decode #(.NCH(NCH)) u_dec (
        .addr   (addr),
        .wr_act (stb.wr_act),
        .sel    (sel)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dacif_chan #(.W(W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .sel    (sel[g]),
            .ld_act (stb.ld_act),
            .data   (data),
            .hold_q (hold_stage[g]),
            .conv_q (conv_stage[g])
        );
    end

    dacif_clr #(.NCH(NCH), .W(W)) u_clr (
        .conv_q  (conv_stage),
        .clr_act (stb.clr_act),
        .code    (dac_code)
    );

endmodule

// File: rtl/dacif_octal_chk.sv
module dacif_octal_chk #(
    parameter int unsigned W   = 12,
    parameter int unsigned NCH = 8,
    localparam int unsigned AW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [W-1:0]          data,
    input logic [AW-1:0]         addr,
    input logic                  cs_n,
    input logic                  wr_n,
    input logic                  ld_n,
    input logic                  clr_n,
    input logic [NCH-1:0][W-1:0] dac_code,
    input logic [NCH-1:0][W-1:0] hold_stage,
    input logic [NCH-1:0][W-1:0] conv_stage
);

    // R1: reset empties both stages
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (hold_stage == '0 && conv_stage == '0));

    // R2, R3: a holding stage moves only when it is the addressed write target
    for (genvar g = 0; g < NCH; g++) begin : g_hold
        p_unsel_hold_r3: assert property (@(posedge clk) disable iff (rst)
            !(!cs_n && !wr_n && addr == AW'(g)) |=> $stable(hold_stage[g]));
    end

    // R4: an open write gate loads the bus into the addressed stage
    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n) |=> hold_stage[$past(addr)] == $past(data));

    // R5: a high load strobe freezes every converter stage
    p_ld_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> $stable(conv_stage));

    // R6: a low load strobe with no write copies every holding stage
    p_ld_follow_r6: assert property (@(posedge clk) disable iff (rst)
        (!ld_n && (cs_n || wr_n)) |=> conv_stage == $past(hold_stage));

    // R7: full flow-through in one edge
    p_flow_r7: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && !ld_n) |=>
            (!clr_n || dac_code[$past(addr)] == $past(data)));

    // R8: clear forces zero scale
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> dac_code == '0);

    // R9: releasing clear restores the stored converter codes
    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(clr_n) |-> dac_code == conv_stage);

endmodule

bind dacif_octal dacif_octal_chk #(.W(W), .NCH(NCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .data       (data),
    .addr       (addr),
    .cs_n       (cs_n),
    .wr_n       (wr_n),
    .ld_n       (ld_n),
    .clr_n      (clr_n),
    .dac_code   (dac_code),
    .hold_stage (hold_stage),
    .conv_stage (conv_stage)
);

// File: tb/dacif_octal_tb.sv
module dacif_octal_tb;

    localparam int W   = 12;
    localparam int NCH = 8;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [W-1:0]          data = '0;
    logic [2:0]            addr = '0;
    logic                  cs_n = 1'b1;
    logic                  wr_n = 1'b1;
    logic                  ld_n = 1'b1;
    logic                  clr_n = 1'b1;
    logic [NCH-1:0][W-1:0] dac_code;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] exp_code [NCH];

    always #5 clk = ~clk;

    dacif_octal u_dut (
        .clk      (clk),
        .rst      (rst),
        .data     (data),
        .addr     (addr),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .ld_n     (ld_n),
        .clr_n    (clr_n),
        .dac_code (dac_code)
    );

    task automatic chk(input int ch, input logic [W-1:0] exp, input string req);
        total++;
        if (dac_code[ch] !== exp) begin
            bad++;
            $display("FAIL %s ch%0d actual=%h expected=%h", req, ch, dac_code[ch], exp);
        end
    endtask

    task automatic chk_all(input string req);
        #1;
        for (int k = 0; k < NCH; k++) chk(k, exp_code[k], req);
    endtask

    task automatic chk_zero(input string req);
        #1;
        for (int k = 0; k < NCH; k++) chk(k, '0, req);
    endtask

    task automatic write_ch(input int ch, input logic [W-1:0] v);
        @(negedge clk);
        addr = 3'(ch); data = v; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; data = ~v;
    endtask

    task automatic pulse_load();
        @(negedge clk);
        ld_n = 1'b0;
        @(negedge clk);
        ld_n = 1'b1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NCH; k++) exp_code[k] = '0;
        chk_all("R1");
    endtask

    task automatic t_addr();
        for (int k = 0; k < NCH; k++) write_ch(k, 12'h100 + 12'(k * 17));
        chk_all("R5");                  // nothing loaded yet
        pulse_load();
        for (int k = 0; k < NCH; k++) exp_code[k] = 12'h100 + 12'(k * 17);
        chk_all("R2 R6 R10");
    endtask

    task automatic t_ignore();
        @(negedge clk);
        addr = 3'd2; data = 12'hFFF; cs_n = 1'b1; wr_n = 1'b0;
        @(negedge clk);
        data = 12'hABC;
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b1; data = 12'hEEE;
        @(negedge clk);
        cs_n = 1'b1;
        pulse_load();
        chk_all("R3");
    endtask

    task automatic t_track();
        @(negedge clk);
        addr = 3'd3; data = 12'hAAA; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        data = 12'h555;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; data = 12'h777;
        pulse_load();
        exp_code[3] = 12'h555;
        #1 chk(3, exp_code[3], "R4");
    endtask

    task automatic t_hold();
        write_ch(5, 12'h321);
        #1 chk(5, exp_code[5], "R5");
        pulse_load();
        exp_code[5] = 12'h321;
        chk_all("R6");
    endtask

    task automatic t_flow();
        @(negedge clk);
        addr = 3'd6; data = 12'h9A1; cs_n = 1'b0; wr_n = 1'b0; ld_n = 1'b0;
        @(negedge clk);
        exp_code[6] = 12'h9A1;
        #1 chk(6, exp_code[6], "R7");
        data = 12'h0F0;
        @(negedge clk);
        exp_code[6] = 12'h0F0;
        cs_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1;
        chk_all("R7");
    endtask

    task automatic t_clear();
        @(negedge clk);
        clr_n = 1'b0;
        chk_zero("R8");
        write_ch(1, 12'h444);
        pulse_load();
        chk_zero("R8");
        @(negedge clk);
        clr_n = 1'b1;
        exp_code[1] = 12'h444;
        chk_all("R9");
    endtask

    initial begin
        t_reset();
        t_addr();
        t_ignore();
        t_track();
        t_hold();
        t_flow();
        t_clear();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule